// File: doc/BRIEF.md
# Quad-Pumped Bus Data Capture with Group Polarity Restore

This block receives a wide, active-low, source-synchronous data bus on which four transfers travel in every bus clock. The bus is split into 16-bit groups. Each group has its own pair of strobes: an even strobe and an odd strobe, both active on their falling edge. Each group also has its own active-low inversion flag. Strobes, data, flags, data-ready and bus-busy are all oversampled by one fast synchronous clock, which must run at least eight times the bus clock. A falling strobe edge is recognised when the previous registered sample was high and the current registered sample is low.

Each group fills its transfer slots on its own. When every group holds all four transfers, the block emits one 256-bit beat with a single-cycle valid. Transfer 0 goes in the lowest 64 bits and transfer 3 in the highest. If the busy line is released while a beat is only partly captured, that capture is dropped and an error pulse is raised.

The output is a stream with no back-pressure. A source-synchronous bus cannot be stalled, so no ready input exists. The consumer must take `beat_data` in the cycle `beat_valid` is high. The register then holds that beat until the next one replaces it.

Top module: `qp_beat_capture`

## Requirements
- R1: After reset, `beat_valid` and `beat_err` are low and `beat_data` is all zeros.
- R2: A completed beat places transfer t of the bus, for t = 0 to 3, in `beat_data[64*t+63 : 64*t]`.
- R3: In each group, a falling edge of the even strobe fills slots 0 and 2, and a falling edge of the odd strobe fills slots 1 and 3. A falling edge of the strobe that does not match the next slot's parity is ignored.
- R4: Group g (bits 16g+15 : 16g) is captured only by strobe pair g. A beat is issued only once every group has filled all four slots, whatever the order in which the groups fill.
- R5: Each transfer's group value is taken with its own inversion flag, sampled together with the data. With `inv_n[g]` = 0 the pins are taken as they are. With `inv_n[g]` = 1 the pins are complemented.
- R6: A strobe edge seen while `drdy_n` is high captures nothing and does not advance the slot.
- R7: `beat_valid` is high for exactly one cycle per completed beat, and all groups then restart at slot 0.
- R8: A rising edge of `busy_n` while any group has a partial capture discards the capture and pulses `beat_err` for one cycle, with no beat issued. A release with nothing captured raises no error.
- R9: `beat_data` holds its value between valid pulses, whatever the bus pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock (at least 8x the bus clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_d_n | input | 64 | Raw active-low data pins |
| stb_even_n | input | 4 | Per-group even strobes; a falling edge captures slots 0 and 2 |
| stb_odd_n | input | 4 | Per-group odd strobes; a falling edge captures slots 1 and 3 |
| inv_n | input | 4 | Per-group inversion flags, active low |
| drdy_n | input | 1 | Data-ready, active low |
| busy_n | input | 1 | Data bus busy, active low |
| beat_valid | output | 1 | One-cycle pulse marking a new beat |
| beat_data | output | 256 | Assembled beat, transfer 0 in the lowest bits |
| beat_err | output | 1 | One-cycle pulse when a partial beat is discarded |

## Verification
Directed beats with inversion off, then with it on, separate the polarity paths from the slot ordering. Random beats with a random inversion flag per group and per transfer expose any flag that is sampled on the wrong transfer. Edges that arrive without data-ready, or on the wrong-parity strobe, must leave the beat unchanged. Groups filled at different times must yield nothing until the last group completes. A busy release in mid-beat must give an error and no beat, and the following clean beat must carry no leftover data.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;
  localparam int unsigned QPC_GROUP_W = 16;
  localparam int unsigned QPC_GROUPS  = 4;
  localparam int unsigned QPC_XFERS   = 4;

  // Which strobe of a pair the next slot waits for (slot parity).
  typedef enum logic {
    STB_EVEN = 1'b0,
    STB_ODD  = 1'b1
  } stb_sel_e;
endpackage

// File: rtl/qpc_edge_sync.sv
`timescale 1ns/1ps
module qpc_edge_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  // Idle level of every sampled line is high.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur  <= '1;
      prev <= '1;
    end else begin
      cur  <= raw;
      prev <= cur;
    end
  end

  assign fall = prev & ~cur;
  assign rise = ~prev & cur;
endmodule

// File: rtl/qpc_lane.sv
`timescale 1ns/1ps
module qpc_lane
  import qpc_pkg::*;
#(
  parameter int unsigned GROUP_W = QPC_GROUP_W,
  parameter int unsigned XFERS   = QPC_XFERS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       even_fall,
  input  logic                       odd_fall,
  input  logic                       rdy,
  input  logic                       inv,
  input  logic [GROUP_W-1:0]         pins,
  output logic                       full,
  output logic                       started,
  output logic [XFERS*GROUP_W-1:0]   data
);
  localparam int unsigned CNT_W = $clog2(XFERS + 1);

  logic [CNT_W-1:0]   count;
  logic [GROUP_W-1:0] store [XFERS];
  logic [GROUP_W-1:0] decoded;
  stb_sel_e           want;
  logic               edge_ok;
  logic               take;

  assign want    = stb_sel_e'(count[0]);
  assign edge_ok = (want == STB_ODD) ? odd_fall : even_fall;
  assign full    = (count == CNT_W'(XFERS));
  assign started = (count != '0);
  assign take    = rdy && !full && edge_ok;
  // Flag asserted: pins carry the value as is; otherwise active low.
  assign decoded = inv ? pins : ~pins;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < int'(XFERS); i++) store[i] <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (take) begin
      count <= count + CNT_W'(1);
      for (int i = 0; i < int'(XFERS); i++)
        if (count == CNT_W'(i)) store[i] <= decoded;
    end
  end

  for (genvar t = 0; t < int'(XFERS); t++) begin : g_pack
    assign data[t*GROUP_W +: GROUP_W] = store[t];
  end

  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(XFERS));
  assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == '0 || count == CNT_W'($past(count) + CNT_W'(1))));
  assert_no_take_unready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |=> (count == $past(count) || count == '0));
endmodule

// File: rtl/qp_beat_capture.sv
`timescale 1ns/1ps
module qp_beat_capture
  import qpc_pkg::*;
#(
  parameter int unsigned GROUP_W = QPC_GROUP_W,
  parameter int unsigned GROUPS  = QPC_GROUPS,
  parameter int unsigned XFERS   = QPC_XFERS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [GROUP_W*GROUPS-1:0]         bus_d_n,
  input  logic [GROUPS-1:0]                 stb_even_n,
  input  logic [GROUPS-1:0]                 stb_odd_n,
  input  logic [GROUPS-1:0]                 inv_n,
  input  logic                              drdy_n,
  input  logic                              busy_n,
  output logic                              beat_valid,
  output logic [GROUP_W*GROUPS*XFERS-1:0]   beat_data,
  output logic                              beat_err
);
  localparam int unsigned BUS_W  = GROUP_W * GROUPS;
  localparam int unsigned BEAT_W = BUS_W * XFERS;
  localparam int unsigned SYNC_W = BUS_W + 3 * GROUPS + 2;
  localparam int unsigned O_EVN  = BUS_W;
  localparam int unsigned O_ODD  = BUS_W + GROUPS;
  localparam int unsigned O_INV  = BUS_W + 2 * GROUPS;
  localparam int unsigned O_RDY  = BUS_W + 3 * GROUPS;
  localparam int unsigned O_BSY  = O_RDY + 1;

  logic [SYNC_W-1:0] s_cur, s_fall, s_rise;
  logic [GROUPS-1:0] full, started;
  logic [XFERS*GROUP_W-1:0] lane_data [GROUPS];
  logic [BEAT_W-1:0] assembled;
  logic all_full, any_started, release_ev, discard, clear;

  qpc_edge_sync #(.W(SYNC_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({busy_n, drdy_n, inv_n, stb_odd_n, stb_even_n, bus_d_n}),
    .cur  (s_cur),
    .fall (s_fall),
    .rise (s_rise)
  );

  for (genvar g = 0; g < int'(GROUPS); g++) begin : g_lane
    qpc_lane #(.GROUP_W(GROUP_W), .XFERS(XFERS)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .even_fall(s_fall[O_EVN + g]),
      .odd_fall (s_fall[O_ODD + g]),
      .rdy      (~s_cur[O_RDY]),
      .inv      (~s_cur[O_INV + g]),
      .pins     (s_cur[g*GROUP_W +: GROUP_W]),
      .full     (full[g]),
      .started  (started[g]),
      .data     (lane_data[g])
    );
    for (genvar t = 0; t < int'(XFERS); t++) begin : g_place
      assign assembled[t*BUS_W + g*GROUP_W +: GROUP_W] = lane_data[g][t*GROUP_W +: GROUP_W];
    end
  end

  assign all_full    = &full;
  assign any_started = |started;
  assign release_ev  = s_rise[O_BSY];
  assign discard     = release_ev && any_started && !all_full;
  assign clear       = all_full || discard;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_valid <= 1'b0;
      beat_err   <= 1'b0;
      beat_data  <= '0;
    end else begin
      beat_valid <= all_full;
      beat_err   <= discard;
      if (all_full) beat_data <= assembled;
    end
  end

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |=> !beat_valid);
  assert_valid_from_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> $past(all_full));
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_err |=> !beat_err);
  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_valid && beat_err));
  assert_beat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> $stable(beat_data));
endmodule

// File: tb/qp_beat_capture_tb_top.sv
`timescale 1ns/1ps
module qp_beat_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] bus_d_n = '1;
  logic [3:0]  stb_even_n = '1, stb_odd_n = '1, inv_n = '1;
  logic        drdy_n = 1'b1, busy_n = 1'b1;
  logic        beat_valid, beat_err;
  logic [255:0] beat_data;

  int nchk = 0, nfail = 0, nvalid = 0, nerr = 0;
  logic [255:0] last_beat = '0;
  logic [63:0] xv [4];
  logic [3:0]  xi [4];

  always #2.5 clk = ~clk;

  qp_beat_capture dut_i (
    .clk(clk), .rst_n(rst_n), .bus_d_n(bus_d_n), .stb_even_n(stb_even_n),
    .stb_odd_n(stb_odd_n), .inv_n(inv_n), .drdy_n(drdy_n), .busy_n(busy_n),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_err(beat_err)
  );

  always @(negedge clk) begin
    if (beat_valid) begin nvalid++; last_beat = beat_data; end
    if (beat_err) nerr++;
  end

  function automatic logic [63:0] enc(input logic [63:0] v, input logic [3:0] inv);
    logic [63:0] p;
    for (int g = 0; g < 4; g++) p[g*16 +: 16] = inv[g] ? v[g*16 +: 16] : ~v[g*16 +: 16];
    return p;
  endfunction

  function automatic logic [255:0] exp_beat();
    return {xv[3], xv[2], xv[1], xv[0]};
  endfunction

  task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic [63:0] v, input logic [3:0] inv, input bit odd,
                      input logic [3:0] gm, input bit rdy);
    bus_d_n = enc(v, inv);
    inv_n   = ~inv;
    drdy_n  = ~rdy;
    repeat (2) @(negedge clk);
    if (odd) stb_odd_n = ~gm; else stb_even_n = ~gm;
    repeat (2) @(negedge clk);
    stb_even_n = '1; stb_odd_n = '1;
    @(negedge clk);
    drdy_n = 1'b1;
    bus_d_n = 64'(urand64());
  endtask

  function automatic logic [63:0] urand64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic beat(input logic [3:0] gm);
    busy_n = 1'b0;
    for (int t = 0; t < 4; t++) xfer(xv[t], xi[t], t[0], gm, 1'b1);
  endtask

  task automatic finish_bus();
    repeat (4) @(negedge clk);
    busy_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired got running exp done");
    summary();
  end

  initial begin
    int v0, e0;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 valid", 256'(beat_valid), 256'(0));
    chk("R1 err", 256'(beat_err), 256'(0));
    chk("R1 data", beat_data, '0);

    // R2/R4: directed beat, no inversion
    for (int t = 0; t < 4; t++) begin
      xv[t] = {16'(16'hA000 + 4*t + 3), 16'(16'hA000 + 4*t + 2), 16'(16'hA000 + 4*t + 1), 16'(16'hA000 + 4*t)};
      xi[t] = 4'b0000;
    end
    v0 = nvalid;
    beat(4'hF); finish_bus();
    chk("R7 one pulse", 256'(nvalid - v0), 256'(1));
    chk("R2 order", last_beat, exp_beat());

    // R5: all groups inverted
    for (int t = 0; t < 4; t++) begin xv[t] = urand64(); xi[t] = 4'hF; end
    beat(4'hF); finish_bus();
    chk("R5 inverted", last_beat, exp_beat());

    // R6: edge without data-ready ignored
    for (int t = 0; t < 4; t++) begin xv[t] = urand64(); xi[t] = 4'($urandom()); end
    v0 = nvalid;
    busy_n = 1'b0;
    xfer(urand64(), 4'h0, 1'b0, 4'hF, 1'b0);
    for (int t = 0; t < 4; t++) xfer(xv[t], xi[t], t[0], 4'hF, 1'b1);
    xfer(urand64(), 4'h0, 1'b0, 4'hF, 1'b0);
    finish_bus();
    chk("R6 not ready skipped", last_beat, exp_beat());
    chk("R6 single beat", 256'(nvalid - v0), 256'(1));

    // R3: wrong-parity strobe edges ignored
    for (int t = 0; t < 4; t++) begin xv[t] = urand64(); xi[t] = 4'($urandom()); end
    busy_n = 1'b0;
    xfer(urand64(), 4'h3, 1'b1, 4'hF, 1'b1);
    xfer(xv[0], xi[0], 1'b0, 4'hF, 1'b1);
    xfer(urand64(), 4'h5, 1'b0, 4'hF, 1'b1);
    for (int t = 1; t < 4; t++) xfer(xv[t], xi[t], t[0], 4'hF, 1'b1);
    finish_bus();
    chk("R3 parity", last_beat, exp_beat());

    // R4: groups filled at different times
    begin
      logic [63:0] a [4];
      logic [63:0] b [4];
      for (int t = 0; t < 4; t++) begin a[t] = urand64(); b[t] = urand64(); xi[t] = 4'($urandom()); end
      v0 = nvalid;
      busy_n = 1'b0;
      for (int t = 0; t < 4; t++) xfer(a[t], xi[t], t[0], 4'b0011, 1'b1);
      repeat (4) @(negedge clk);
      chk("R4 no early beat", 256'(nvalid - v0), 256'(0));
      for (int t = 0; t < 4; t++) xfer(b[t], xi[t], t[0], 4'b1100, 1'b1);
      for (int t = 0; t < 4; t++) xv[t] = {b[t][63:32], a[t][31:0]};
      finish_bus();
      chk("R4 staggered", last_beat, exp_beat());
    end

    // R8: release mid-beat discards
    v0 = nvalid; e0 = nerr;
    busy_n = 1'b0;
    xfer(urand64(), 4'h0, 1'b0, 4'hF, 1'b1);
    xfer(urand64(), 4'h0, 1'b1, 4'hF, 1'b1);
    finish_bus();
    chk("R8 err pulse", 256'(nerr - e0), 256'(1));
    chk("R8 no beat", 256'(nvalid - v0), 256'(0));
    for (int t = 0; t < 4; t++) begin xv[t] = urand64(); xi[t] = 4'($urandom()); end
    beat(4'hF); finish_bus();
    chk("R8 clean after discard", last_beat, exp_beat());
    chk("R8 idle release no err", 256'(nerr - e0), 256'(1));

    // R9: output holds while pins toggle
    for (int i = 0; i < 12; i++) begin bus_d_n = urand64(); inv_n = 4'($urandom()); @(negedge clk); end
    chk("R9 hold", beat_data, exp_beat());

    // R2/R5/R7: random beats
    for (int k = 0; k < 20; k++) begin
      for (int t = 0; t < 4; t++) begin xv[t] = urand64(); xi[t] = 4'($urandom()); end
      v0 = nvalid;
      beat(4'hF); finish_bus();
      chk("R5 random beat", last_beat, exp_beat());
      chk("R7 random pulse", 256'(nvalid - v0), 256'(1));
    end

    summary();
  end
endmodule